// File: doc/BRIEF.md
# Level Interrupt Cause and Mask Unit

This block gathers seven hardware event sources into one level-sensitive interrupt line. Each source owns one bit of a cause register. A pulse or level on an event input sets the bit, and the bit stays set until software clears it. A mask register chooses which cause bits may drive the interrupt line. The line stays high for as long as any enabled cause bit remains set.

Software reaches both registers over a simple register bus. The bus has a write strobe, an address, write data, and read data that is decoded combinationally from the address. The cause register is plain read/write, not write-one-to-clear: each bit takes the value written. Writing a one therefore raises that interrupt, and software clears a bit by writing back the whole register with that bit at zero. To keep an event from being lost during such a write, a hardware event always wins over a bus write of zero to the same bit.

The unit also reports, as a read-only side output, the index of the highest-numbered pending enabled source and a flag that says whether any such source exists. A handler can use this to service sources from the top down.

Top module: `irq_cause_unit`

## Requirements
- R1: While reset is asserted, and after it is released, cause and mask are zero. In that state `irq_o` and `top_vld_o` are low, `top_idx_o` is 0, and both registers read as zero.
- R2: A bus write to offset 0x50 loads cause bits 6:0 with write-data bits 6:0. Writing a 1 sets a bit and writing a 0 clears it. The new value reads back from 0x50 from the following cycle.
- R3: A bus write to offset 0x54 loads mask bits 6:0 with write-data bits 6:0. A 1 enables a source and a 0 masks it. The new value reads back from 0x54 from the following cycle.
- R4: An event input bit k that is high at a clock edge sets cause bit k whatever the mask holds. The bit then stays set, with no further event, until a bus write clears it.
- R5: If event bit k is high in the same cycle as a write to 0x50 with data bit k at 0, cause bit k ends up set.
- R6: `irq_o` is high exactly when the bitwise AND of cause and mask is non-zero. It follows each register update from the next cycle.
- R7: `top_vld_o` equals `irq_o`. `top_idx_o` is the highest bit position set in cause AND mask, and 0 when none is set.
- R8: Register bits 31 to 7 of both registers read as zero, and written values in those bits have no effect.
- R9: A write to any offset other than 0x50 and 0x54 changes neither register, and a read of such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_i | input | 7 | Event inputs; a high bit sets the matching cause bit |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 8 | Bus byte offset for reads and writes |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data for `addr`, combinational |
| irq_o | output | 1 | Level interrupt output |
| top_idx_o | output | 3 | Highest pending enabled source index |
| top_vld_o | output | 1 | High when any enabled source is pending |

## Verification
The bench first targets the race between a clearing write and a new event in the same cycle. A design that lets the write win would silently drop that event and leave the cause bit at zero.

It then writes a one to a cause bit with no event present. A design built as write-one-to-clear would clear the bit instead of raising the interrupt.

Masked sources are set, then unmasked and masked again, to catch a line or index that ignores the mask or picks the lowest pending bit. Writes with all upper bits set, and writes to an unmapped offset, catch a decoder that leaks into the registers or reads back stray bits.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
    localparam int unsigned IRQ_NUM_SRC   = 7;
    localparam int unsigned IRQ_DATA_W    = 32;
    localparam int unsigned IRQ_ADDR_W    = 8;
    localparam logic [IRQ_ADDR_W-1:0] IRQ_CAUSE_OFS = 8'h50;
    localparam logic [IRQ_ADDR_W-1:0] IRQ_MASK_OFS  = 8'h54;
endpackage

// File: rtl/irq_cause_regs.sv
module irq_cause_regs #(
    parameter int unsigned NUM_SRC = 7,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'h50,
    parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h54
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ev_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SRC-1:0] cause_o,
    output logic [NUM_SRC-1:0] mask_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] cause;
        logic [NUM_SRC-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == CAUSE_OFS)
            st_d.cause = wdata[NUM_SRC-1:0];
        if (wr_en && addr == MASK_OFS)
            st_d.mask = wdata[NUM_SRC-1:0];
        // Events override a concurrent clearing write
        st_d.cause = st_d.cause | ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned NUM_SRC = 7,
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               vld_o
);
    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i]) begin
                idx_o = i[IDX_W-1:0];
                vld_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
    parameter int unsigned NUM_SRC = 7,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'h50,
    parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h54
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] cause_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [DATA_W-1:0]  rdata
);
    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    always_comb begin
        rdata = '0;
        if (addr == CAUSE_OFS)
            rdata = {{PAD_W{1'b0}}, cause_i};
        else if (addr == MASK_OFS)
            rdata = {{PAD_W{1'b0}}, mask_i};
    end
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
    import irq_cause_pkg::*;
#(
    parameter int unsigned NUM_SRC = IRQ_NUM_SRC,
    parameter int unsigned DATA_W  = IRQ_DATA_W,
    parameter int unsigned ADDR_W  = IRQ_ADDR_W,
    parameter logic [ADDR_W-1:0] CAUSE_OFS = IRQ_CAUSE_OFS,
    parameter logic [ADDR_W-1:0] MASK_OFS  = IRQ_MASK_OFS,
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ev_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_o,
    output logic [IDX_W-1:0]   top_idx_o,
    output logic               top_vld_o
);
    logic [NUM_SRC-1:0] cause_w;
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] pend_w;

    irq_cause_regs #(
        .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .cause_o(cause_w), .mask_o(mask_w)
    );

    assign pend_w = cause_w & mask_w;

    irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_prio (
        .pend_i(pend_w), .idx_o(top_idx_o), .vld_o(top_vld_o)
    );

    assign irq_o = |pend_w;

    irq_rd_mux #(
        .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)
    ) u_rd (
        .addr(addr), .cause_i(cause_w), .mask_i(mask_w), .rdata(rdata)
    );
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk #(
    parameter int unsigned NUM_SRC = 7,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'h50,
    parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h54,
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] ev_i,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [NUM_SRC-1:0] cause_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               irq_o,
    input logic [IDX_W-1:0]   top_idx_o,
    input logic               top_vld_o
);
    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((cause_q & $past(ev_i)) == $past(ev_i))); // R4

    AST_CAUSE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CAUSE_OFS) |=>
        (cause_q == ($past(wdata[NUM_SRC-1:0]) | $past(ev_i)))); // R5

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MASK_OFS) |=> (mask_q == $past(wdata[NUM_SRC-1:0]))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && ev_i == '0) |=> ($stable(cause_q) && $stable(mask_q))); // R9

    AST_VLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        top_vld_o == irq_o); // R7

    AST_IDX_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        top_vld_o |-> (((cause_q & mask_q) >> top_idx_o) == 1)); // R7

    AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (top_idx_o == '0)); // R6
endmodule

bind irq_cause_unit irq_cause_chk #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .cause_q(cause_w), .mask_q(mask_w), .irq_o(irq_o),
    .top_idx_o(top_idx_o), .top_vld_o(top_vld_o)
);

// File: tb/irq_cause_unit_test.sv
`timescale 1ns/1ps
module irq_cause_unit_test;
    localparam real CYC = 8.0;
    localparam logic [7:0] A_C = 8'h50;
    localparam logic [7:0] A_M = 8'h54;
    localparam logic [7:0] A_X = 8'h58;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ev_i = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;
    logic [2:0]  top_idx_o;
    logic        top_vld_o;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CYC/2) clk = ~clk;

    irq_cause_unit uut (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
        .top_idx_o(top_idx_o), .top_vld_o(top_vld_o)
    );

    typedef struct packed {
        logic        we;
        logic [7:0]  a;
        logic [31:0] d;
        logic [6:0]  ev;
        logic [6:0]  exp_c;
        logic [6:0]  exp_m;
        logic        exp_irq;
        logic [2:0]  exp_idx;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, A_M, 32'h0000_007F, 7'h00, 7'h00, 7'h7F, 1'b0, 3'd0},
        '{1'b0, A_C, 32'h0,         7'h01, 7'h01, 7'h7F, 1'b1, 3'd0},
        '{1'b0, A_C, 32'h0,         7'h20, 7'h21, 7'h7F, 1'b1, 3'd5},
        '{1'b1, A_C, 32'h0000_0001, 7'h00, 7'h01, 7'h7F, 1'b1, 3'd0},
        '{1'b1, A_C, 32'h0000_0040, 7'h00, 7'h40, 7'h7F, 1'b1, 3'd6},
        '{1'b1, A_M, 32'h0000_000F, 7'h00, 7'h40, 7'h0F, 1'b0, 3'd0},
        '{1'b0, A_C, 32'h0,         7'h0A, 7'h4A, 7'h0F, 1'b1, 3'd3},
        '{1'b1, A_C, 32'h0000_0000, 7'h04, 7'h04, 7'h0F, 1'b1, 3'd2},
        '{1'b1, A_M, 32'hFFFF_FF80, 7'h00, 7'h04, 7'h00, 1'b0, 3'd0},
        '{1'b1, A_X, 32'h0000_007F, 7'h00, 7'h04, 7'h00, 1'b0, 3'd0},
        '{1'b1, A_C, 32'hFFFF_FFFF, 7'h00, 7'h7F, 7'h00, 1'b0, 3'd0},
        '{1'b1, A_M, 32'h0000_0040, 7'h00, 7'h7F, 7'h40, 1'b1, 3'd6}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic [6:0] ev);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; ev_i = ev;
        @(negedge clk);
        wr_en = 1'b0; ev_i = '0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        logic [31:0] v;
        #(CYC * 2.5);
        // R1: state while reset is held
        rd(A_C, v); chk("R1 cause in reset", v, 32'h0);
        rd(A_M, v); chk("R1 mask in reset", v, 32'h0);
        chk("R1 irq in reset", {31'h0, irq_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 vld after reset", {31'h0, top_vld_o}, 32'h0);
        chk("R1 idx after reset", {29'h0, top_idx_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].we, VEC[i].a, VEC[i].d, VEC[i].ev);
            rd(A_C, v); chk($sformatf("R2 R4 R5 R8 cause vec%0d", i), v, {25'h0, VEC[i].exp_c});
            rd(A_M, v); chk($sformatf("R3 R8 R9 mask vec%0d", i), v, {25'h0, VEC[i].exp_m});
            chk($sformatf("R6 irq vec%0d", i), {31'h0, irq_o}, {31'h0, VEC[i].exp_irq});
            chk($sformatf("R7 vld vec%0d", i), {31'h0, top_vld_o}, {31'h0, VEC[i].exp_irq});
            chk($sformatf("R7 idx vec%0d", i), {29'h0, top_idx_o}, {29'h0, VEC[i].exp_idx});
        end

        // R9: unmapped offset reads zero
        rd(A_X, v); chk("R9 unmapped read", v, 32'h0);

        // R4: set bit persists without further events while idle
        repeat (3) @(negedge clk);
        rd(A_C, v); chk("R4 cause holds idle", v, 32'h0000_007F);

        // R5: clearing write to all bits while event on bit 1 only
        step(1'b1, A_C, 32'h0, 7'h02);
        rd(A_C, v); chk("R5 event beats clear", v, 32'h0000_0002);
        chk("R6 irq masked", {31'h0, irq_o}, 32'h0);

        // R1: reset in the middle of activity
        step(1'b1, A_M, 32'h7F, 7'h00);
        chk("R6 irq unmasked", {31'h0, irq_o}, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        #1;
        chk("R1 irq async reset", {31'h0, irq_o}, 32'h0);
        rd(A_M, v); chk("R1 mask cleared", v, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        rd(A_C, v); chk("R1 cause cleared", v, 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(CYC * 5000);
                errs++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule